// File: doc/BRIEF.md
# Strobed Three-Byte Register Bank

This block is a tiny memory-mapped store of three byte-wide registers sitting on a simple parallel bus. A bus master picks one register with a 2-bit address and qualifies the access with an active-low address strobe. A single read/write line sets the direction. While that line is low, the addressed register presents its byte on the output bus. When the line goes from low to high, the addressed register captures the input bus.

Input data and output data travel on separate buses. The output bus is modelled as a valid-qualified mux. It is either driven by exactly one register, with the valid flag high, or released, with the valid flag low and all data bits at zero. No system clock is involved: the read/write line is the write clock, and decode plus strobe act as the per-register write enables.

Top module: `strobed_reg_bank`

## Requirements
- R1: Address value 0 (binary 00) selects register 0, 1 (01) selects register 1 and 2 (10) selects register 2, for both reads and writes.
- R2: While `as_n` is high, no register drives the output (`dout_vld`=0, `dout`=0x00), and a low-to-high transition of `rw` changes no register.
- R3: While `as_n`=0, `rw`=0 and the address is 0..2, `dout_vld` is 1 and `dout` equals the byte stored in the addressed register.
- R4: A low-to-high transition of `rw`, with `as_n`=0 and the address 0..2, stores `din` into the addressed register.
- R5: Whenever no register is being read, including while `rw` is high, the output is released: `dout_vld`=0 and `dout`=0x00.
- R6: Address 3 (binary 11) selects no register: a write to it changes nothing, and a read leaves the output released.
- R7: At most one register drives the output at any time, so `dout` never merges two registers' bytes.
- R8: Driving `rst_n` low clears all three registers to 0x00.
- R9: A register keeps its byte between writes, and a write to one register never alters the other two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers |
| as_n | input | 1 | Active-low address strobe qualifying every access |
| rw | input | 1 | Low = read; rising edge = write clock |
| addr | input | 2 | Register select (0..2 valid, 3 selects nothing) |
| din | input | 8 | Input data bus, captured on a write |
| dout | output | 8 | Output data bus, 0x00 when released |
| dout_vld | output | 1 | High while a register drives `dout` |

## Verification
The write-path assertions are clocked on the rising edge of `rw`. They assume the master holds `addr` and `din` steady across that edge, lowers `as_n` only while `rw` is low, and changes the address only while the strobe is high. A strobe or address change with `rw` already high would otherwise look like a write edge. The bench's write and read tasks follow this ordering on every access. The one exception is the deliberate strobe-high write attempt, in which `rw` toggles with the strobe released.

// File: rtl/rb3_pkg.sv
package rb3_pkg;
    // Default geometry of the bank
    localparam int unsigned DEF_DATA_W   = 8;
    localparam int unsigned DEF_NUM_REGS = 3;
    localparam int unsigned DEF_ADDR_W   = 2;

    // Direction encoding of the read/write line level
    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;
endpackage

// File: rtl/rb3_decode.sv
module rb3_decode #(
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned NUM_REGS = 3
) (
    input  logic                as_n,
    input  logic                rw,
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel,
    output logic [NUM_REGS-1:0] rd_en
);
    import rb3_pkg::*;

    dir_e dir;
    assign dir = dir_e'(rw);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
        always_comb begin
            sel[g]   = !as_n && (addr == MY_ADDR);
            rd_en[g] = sel[g] && (dir == DIR_READ);
        end
    end

    always_comb begin
        // R2
        strobe_idle_chk: assert (!(as_n && (sel != '0)))
            else $error("select active with strobe released");
        // R6
        unmapped_addr_chk: assert (!(int'(addr) >= NUM_REGS && (sel != '0)))
            else $error("unmapped address selected a register");
    end
endmodule

// File: rtl/rb3_bank.sv
module rb3_bank #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_REGS = 3
) (
    input  logic                             rst_n,
    input  logic                             rw,
    input  logic [NUM_REGS-1:0]              sel,
    input  logic [DATA_W-1:0]                din,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_d;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) regs_d[i] = din;
        end
    end

    // The read/write line is the write clock; decode gates the capture.
    always_ff @(posedge rw or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
        // R4
        capture_chk: assert property (@(posedge rw) disable iff (!rst_n)
            sel[g] |=> regs_q[g] == $past(din))
            else $error("register %0d missed a write", g);
        // R9
        hold_chk: assert property (@(posedge rw) disable iff (!rst_n)
            !sel[g] |=> regs_q[g] == $past(regs_q[g]))
            else $error("register %0d changed without a write", g);
    end
endmodule

// File: rtl/rb3_rdmux.sv
module rb3_rdmux #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_REGS = 3
) (
    input  logic [NUM_REGS-1:0]              rd_en,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
    output logic [DATA_W-1:0]                dout,
    output logic                             dout_vld
);
    always_comb begin
        dout = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_en[i]) dout = dout | regs_q[i];
        end
        dout_vld = |rd_en;
    end

    always_comb begin
        // R7
        single_driver_chk: assert ($onehot0(rd_en))
            else $error("more than one register drives the bus");
        // R5
        released_zero_chk: assert (dout_vld || dout == '0)
            else $error("released bus carries data");
    end
endmodule

// File: rtl/strobed_reg_bank.sv
module strobed_reg_bank #(
    parameter int unsigned DATA_W   = rb3_pkg::DEF_DATA_W,
    parameter int unsigned NUM_REGS = rb3_pkg::DEF_NUM_REGS,
    parameter int unsigned ADDR_W   = rb3_pkg::DEF_ADDR_W
) (
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld
);
    localparam int unsigned SPACE = 1 << ADDR_W;

    logic [NUM_REGS-1:0]             sel;
    logic [NUM_REGS-1:0]             rd_en;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    rb3_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
        .as_n(as_n), .rw(rw), .addr(addr), .sel(sel), .rd_en(rd_en)
    );

    rb3_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
        .rst_n(rst_n), .rw(rw), .sel(sel), .din(din), .regs_q(regs_q)
    );

    rb3_rdmux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_mux (
        .rd_en(rd_en), .regs_q(regs_q), .dout(dout), .dout_vld(dout_vld)
    );

    initial begin
        // R1
        space_fits_chk: assert (NUM_REGS <= SPACE)
            else $error("address too narrow for register count");
    end
endmodule

// File: tb/sim_strobed_reg_bank.sv
module sim_strobed_reg_bank;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       as_n = 1'b1;
    logic       rw = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_vld;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit running = 1'b0;
    int mem [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    strobed_reg_bank u0 (
        .rst_n(rst_n), .as_n(as_n), .rw(rw), .addr(addr),
        .din(din), .dout(dout), .dout_vld(dout_vld)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [7:0] got_d, logic got_v,
                         logic [7:0] exp_d, logic exp_v);
        checks++;
        if (got_d !== exp_d || got_v !== exp_v) begin
            errors++;
            $display("FAIL %s: dout=%h vld=%b expected dout=%h vld=%b",
                     tag, got_d, got_v, exp_d, exp_v);
        end
    endtask

    // Behavioural reference compared on every clock
    always @(negedge clk) begin
        if (running) begin
            logic       ev;
            logic [7:0] ed;
            string      tag;
            ev = !as_n && !rw && addr != 2'd3;
            ed = ev ? 8'(mem[addr]) : 8'h00;
            if (as_n)               tag = "R2";
            else if (addr == 2'd3)  tag = "R6";
            else if (rw)            tag = "R5";
            else                    tag = "R3";
            check(tag, dout, dout_vld, ed, ev);
        end
    end

    task automatic bus_write(logic [1:0] a, logic [7:0] d, bit strobe);
        as_n = 1'b1; rw = 1'b0; tick();
        addr = a; din = d; tick();
        as_n = !strobe; tick();
        rw = 1'b1;
        if (!as_n && a != 2'd3) mem[a] = int'(d);
        tick();
        rw = 1'b0; tick();
        as_n = 1'b1; tick();
    endtask

    task automatic bus_read(logic [1:0] a, logic [7:0] exp_d, logic exp_v,
                            string tag);
        as_n = 1'b1; rw = 1'b0; tick();
        addr = a; tick();
        as_n = 1'b0; tick();
        @(negedge clk);
        check(tag, dout, dout_vld, exp_d, exp_v);
        tick();
        as_n = 1'b1; tick();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                errors++;
                checks++;
                $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, WATCHDOG);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        foreach (mem[i]) mem[i] = 0;
        #1 rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        running = 1'b1;

        // R8: all registers clear after reset
        bus_read(2'd0, 8'h00, 1'b1, "R8");
        bus_read(2'd1, 8'h00, 1'b1, "R8");
        bus_read(2'd2, 8'h00, 1'b1, "R8");

        // R1 R4: distinct pattern per register
        bus_write(2'd0, 8'hA5, 1'b1);
        bus_write(2'd1, 8'h3C, 1'b1);
        bus_write(2'd2, 8'hF0, 1'b1);
        // R1 R3 R7: each read returns exactly its own byte
        bus_read(2'd0, 8'hA5, 1'b1, "R1");
        bus_read(2'd1, 8'h3C, 1'b1, "R7");
        bus_read(2'd2, 8'hF0, 1'b1, "R3");

        // R9: a write to register 1 leaves 0 and 2 intact
        bus_write(2'd1, 8'h11, 1'b1);
        bus_read(2'd0, 8'hA5, 1'b1, "R9");
        bus_read(2'd1, 8'h11, 1'b1, "R4");
        bus_read(2'd2, 8'hF0, 1'b1, "R9");

        // R2: rw edge with the strobe released writes nothing
        bus_write(2'd0, 8'hEE, 1'b0);
        bus_read(2'd0, 8'hA5, 1'b1, "R2");

        // R6: unmapped address ignores writes and never drives
        bus_write(2'd3, 8'h77, 1'b1);
        bus_read(2'd3, 8'h00, 1'b0, "R6");
        bus_read(2'd0, 8'hA5, 1'b1, "R6");
        bus_read(2'd1, 8'h11, 1'b1, "R6");
        bus_read(2'd2, 8'hF0, 1'b1, "R6");

        // R5 R9: rolling patterns, model compared every cycle
        for (int k = 0; k < 30; k++) begin
            logic [1:0] a;
            a = 2'(k % 4);
            bus_write(a, 8'(k * 37 + 5), 1'b1);
            bus_read(2'd0, 8'(mem[0]), 1'b1, "R9");
            bus_read(2'd2, 8'(mem[2]), 1'b1, "R9");
        end

        running = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule